// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This controller gathers 72 level-sensitive interrupt lines: a group of 8 direct lines and two banks of 32 lines each. Every line has its own enable bit. Software sets enable bits through one register per group and clears them through a second register per group. In both registers a 1 acts on that bit and a 0 leaves the bit alone, so software never has to read, modify and write a mask.

A line is pending while its input is high and its enable bit is set. Pending is not latched: it follows the input level. Each bank's pending bits can be read as a word. A summary word gathers, in one read, the eight direct lines, one "other bank activity" flag per bank, and shortcut copies of eleven frequently used bank lines, so a handler can often find its source without a second read. One output, the OR of every pending line, requests service. A fast-interrupt control word is stored and read back. It does not steer any line.

Lines are numbered 0–7 for the direct group, 8–39 for bank 1 (bank bit = number − 8) and 40–71 for bank 2 (bank bit = number − 40).

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset all 72 enable bits and the fast-interrupt control word are zero, and `irq` is low whatever the inputs are.
- R2: A write to offset 0x10 (bank 1), 0x14 (bank 2) or 0x18 (direct group) sets the enable of every bit written as 1, from the next clock edge. Bits written as 0 keep their enable.
- R3: A write to offset 0x1C (bank 1), 0x20 (bank 2) or 0x24 (direct group) clears the enable of every bit written as 1, from the next clock edge. Bits written as 0 keep their enable.
- R4: A read of a group's enable offset or its disable offset returns that group's current enable mask.
- R5: Offset 0x04 reads bank 1 pending and offset 0x08 reads bank 2 pending. A bit reads 1 only while its input is high and its enable is set, and it drops as soon as the input drops.
- R6: Summary word (offset 0x00) bits 7:0 are the pending direct lines.
- R7: Summary bit 8 is set when any pending bank 1 bit is outside the shortcut set {7, 9, 10, 18, 19}. Summary bit 9 is set when any pending bank 2 bit is outside {21, 22, 23, 24, 25, 30}.
- R8: Summary bits 10–14 copy pending bank 1 bits 7, 9, 10, 18, 19, in that order. Summary bits 15–20 copy pending bank 2 bits 21, 22, 23, 24, 25, 30, in that order.
- R9: Summary bits 31:21 read zero, and every unmapped offset reads zero.
- R10: `irq` is high exactly when at least one of the 72 lines is pending.
- R11: Offset 0x0C stores a 32-bit word that reads back as written and has no effect on `irq` or on pending status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, acts at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_direct | input | 8 | Direct-group interrupt levels |
| src_bank1 | input | 32 | Bank 1 interrupt levels |
| src_bank2 | input | 32 | Bank 2 interrupt levels |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the controller with its default 6-bit offset width. That width reaches every mapped offset and also some unmapped ones above 0x24, which R9 requires to read zero. With every line enabled, a vector table drives patterns that each hit one summary feature alone: a direct line, a shortcut line, a non-shortcut bank line, and a mix of all of these. Directed tests then cover set and clear masks with zero bits that must leave enables alone, pending that drops when its input drops, disabled lines that keep `irq` low, and readback of the fast-interrupt word.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [7:0]        src_direct,
  input  logic [31:0]       src_bank1,
  input  logic [31:0]       src_bank2,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] OFS_SUMMARY = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_PEND1   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_PEND2   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_FASTCTL = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_SET1    = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_SET2    = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_SETD    = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_CLR1    = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFS_CLR2    = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFS_CLRD    = ADDR_W'(8'h24);

  localparam logic [31:0] SHORT1 = 32'h000C_0680;
  localparam logic [31:0] SHORT2 = 32'h43E0_0000;

  logic [7:0]  en_direct;
  logic [31:0] en_bank1, en_bank2, fast_ctl;
  logic [7:0]  pend_direct;
  logic [31:0] pend1, pend2, summary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_direct <= '0;
      en_bank1  <= '0;
      en_bank2  <= '0;
      fast_ctl  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_SET1:    en_bank1  <= en_bank1 | reg_wdata;
        OFS_SET2:    en_bank2  <= en_bank2 | reg_wdata;
        OFS_SETD:    en_direct <= en_direct | reg_wdata[7:0];
        OFS_CLR1:    en_bank1  <= en_bank1 & ~reg_wdata;
        OFS_CLR2:    en_bank2  <= en_bank2 & ~reg_wdata;
        OFS_CLRD:    en_direct <= en_direct & ~reg_wdata[7:0];
        OFS_FASTCTL: fast_ctl  <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign pend_direct = src_direct & en_direct;
  assign pend1       = src_bank1 & en_bank1;
  assign pend2       = src_bank2 & en_bank2;

  assign summary = {11'd0,
                    pend2[30], pend2[25], pend2[24], pend2[23], pend2[22], pend2[21],
                    pend1[19], pend1[18], pend1[10], pend1[9], pend1[7],
                    |(pend2 & ~SHORT2), |(pend1 & ~SHORT1),
                    pend_direct};

  assign irq = |pend_direct | |pend1 | |pend2;

  always_comb begin
    case (reg_addr)
      OFS_SUMMARY:          reg_rdata = summary;
      OFS_PEND1:            reg_rdata = pend1;
      OFS_PEND2:            reg_rdata = pend2;
      OFS_FASTCTL:          reg_rdata = fast_ctl;
      OFS_SET1, OFS_CLR1:   reg_rdata = en_bank1;
      OFS_SET2, OFS_CLR2:   reg_rdata = en_bank2;
      OFS_SETD, OFS_CLRD:   reg_rdata = {24'd0, en_direct};
      default:              reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [7:0]        src_direct,
  input logic [31:0]       src_bank1,
  input logic [31:0]       src_bank2,
  input logic              irq,
  input logic [31:0]       en_bank1,
  input logic [7:0]        en_direct
);

  a_r2_set_bank1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8'h10)) |=> ((en_bank1 & $past(reg_wdata)) == $past(reg_wdata)));

  a_r3_clear_bank1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8'h1C)) |=> ((en_bank1 & $past(reg_wdata)) == 32'd0));

  a_r2_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(en_bank1) && $stable(en_direct)));

  a_r10_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|src_direct || |src_bank1 || |src_bank2));

  a_r9_summary_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8'h00)) |-> (reg_rdata[31:21] == 11'd0));

endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_direct(src_direct),
  .src_bank1(src_bank1), .src_bank2(src_bank2), .irq(irq),
  .en_bank1(en_bank1), .en_direct(en_direct)
);

// File: tb/banked_irq_ctrl_tb.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb;
  localparam int ADDR_W = 6;
  localparam int NV = 9;
  // {src_direct, src_bank1, src_bank2, expected summary, expected irq}
  localparam logic [104:0] VEC [NV] = '{
    {8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {8'h81, 32'h0000_0000, 32'h0000_0000, 32'h0000_0081, 1'b1},
    {8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400, 1'b1},
    {8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100, 1'b1},
    {8'h00, 32'h000C_0600, 32'h0000_0000, 32'h0000_7800, 1'b1},
    {8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000, 1'b1},
    {8'h00, 32'h0000_0000, 32'h03E0_0000, 32'h000F_8000, 1'b1},
    {8'h00, 32'h0000_0000, 32'h0000_0004, 32'h0000_0200, 1'b1},
    {8'h02, 32'h0000_0081, 32'h8020_0000, 32'h0000_8702, 1'b1}
  };

  logic clk = 0, rst_n = 0, reg_wr = 0, irq;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, src_bank1 = '0, src_bank2 = '0;
  logic [7:0] src_direct = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  banked_irq_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_direct(src_direct),
    .src_bank1(src_bank1), .src_bank2(src_bank2), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a[ADDR_W-1:0]; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a[ADDR_W-1:0];
    #1 d = reg_rdata;
  endtask

  task automatic summary_line;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_line();
    $finish;
  end

  initial begin
    logic [31:0] r;
    src_direct = 8'hFF; src_bank1 = '1; src_bank2 = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h10, r); check("R1 bank1 enable", r, 0);
    rd(8'h14, r); check("R1 bank2 enable", r, 0);
    rd(8'h18, r); check("R1 direct enable", r, 0);
    rd(8'h0C, r); check("R1 fast ctl", r, 0);
    check("R1 irq low", {31'd0, irq}, 0);
    // R10 disabled sources keep irq low
    check("R10 no pending no irq", {31'd0, irq}, 0);
    src_direct = 0; src_bank1 = 0; src_bank2 = 0;

    // Vector table with everything enabled
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFF);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {src_direct, src_bank1, src_bank2} = VEC[i][104:33];
      rd(8'h00, r); check("R6 R7 R8 summary", r, VEC[i][32:1]);
      rd(8'h04, r); check("R5 bank1 pending", r, VEC[i][96:65]);
      rd(8'h08, r); check("R5 bank2 pending", r, VEC[i][64:33]);
      check("R10 irq", {31'd0, irq}, {31'd0, VEC[i][0]});
    end
    src_direct = 0; src_bank1 = 0; src_bank2 = 0;

    // R3 / R2 partial masks
    wr(8'h1C, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF); wr(8'h24, 32'hFF);
    rd(8'h10, r); check("R3 bank1 cleared", r, 0);
    wr(8'h10, 32'h0000_00F0);
    wr(8'h10, 32'h0000_000F);
    rd(8'h10, r); check("R2 zeros keep enables", r, 32'hFF);
    rd(8'h1C, r); check("R4 disable offset reads mask", r, 32'hFF);
    wr(8'h1C, 32'h0000_000F);
    rd(8'h10, r); check("R3 clear only ones", r, 32'hF0);
    wr(8'h14, 32'h8000_0001);
    rd(8'h20, r); check("R4 bank2 mask via disable offset", r, 32'h8000_0001);
    wr(8'h18, 32'h0000_0005);
    rd(8'h24, r); check("R4 direct mask via disable offset", r, 32'h5);
    wr(8'h24, 32'h0000_0004);
    rd(8'h18, r); check("R3 direct clear", r, 32'h1);

    // R5 level follow
    src_bank1 = '1;
    rd(8'h04, r); check("R5 masked pending", r, 32'hF0);
    rd(8'h00, r); check("R7 non-shortcut flag", r, 32'h0000_0500);
    check("R10 irq from bank1", {31'd0, irq}, 1);
    src_bank1 = '0;
    rd(8'h04, r); check("R5 not latched", r, 0);
    check("R10 irq drops", {31'd0, irq}, 0);
    src_direct = 8'h02;
    check("R10 disabled direct line", {31'd0, irq}, 0);
    src_direct = 8'h01;
    rd(8'h00, r); check("R6 direct pending", r, 32'h1);
    src_direct = 0;

    // R11 fast control
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'h0C, r); check("R11 readback", r, 32'hDEAD_BEEF);
    check("R11 no irq effect", {31'd0, irq}, 0);
    rd(8'h10, r); check("R11 enables untouched", r, 32'hF0);

    // R9 unmapped
    rd(8'h28, r); check("R9 unmapped 0x28", r, 0);
    rd(8'h3C, r); check("R9 unmapped 0x3C", r, 0);

    summary_line();
    $finish;
  end
endmodule